// File: doc/BRIEF.md
# Cascadable LCD Column Data Loader

This block is the digital core of a passive-matrix LCD column driver. Display data arrives over a bus that is either 4 or 8 bits wide and is written into an 80-column line register. Each accepted shift-clock falling edge writes one group of columns. The fill can run from the first column upward or from the last column downward. Writing is gated by an active-low carry-in enable. Once every column is written, the block drives an active-low carry-out, which enables the next device in a chain of drivers.

A falling edge on the line-latch pulse copies the line register into a holding register. The same edge rewinds the fill position and releases the carry-out. Each column's latched bit is then turned into a 2-bit drive-level code, which depends on the frame-alternation input and the active-low blanking input.

All logic runs on one system clock. The shift clock and the latch pulse are synchronised to that clock, and their falling edges are detected as single-cycle strobes. The data bus must stay stable for a few system cycles around each shift-clock falling edge.

Top module: `lcd_col_loader`

## Requirements
- R1: After reset the holding register is all zero, the fill position is empty and the active carry-out pin is high. With `m_frame_i`=0 and `blank_n_i`=1, every column therefore shows code 01.
- R2: One transfer is taken per shift-clock falling edge and none on a rising edge. `bus_wide_i`=0 takes `data_i[3:0]` and ignores the upper bits, so 20 transfers fill a line. `bus_wide_i`=1 takes `data_i[7:0]`, so 10 transfers fill a line.
- R3: With `fill_dir_i`=1, bit k of transfer t (counting from 0) goes to column t*W+k+1, where W is the bus width. Column n is `col_level_o[2n-1:2n-2]`.
- R4: With `fill_dir_i`=0, bit k of transfer t goes to column 80-(t*W+k). The first transfer's bit 0 therefore lands on column 80.
- R5: With `fill_dir_i`=0, pin A is the carry input (`carry_a_oe`=0) and pin B is the carry output (`carry_b_oe`=1). With `fill_dir_i`=1 the two roles swap. An inactive output pin drives 1.
- R6: Transfers are ignored while the selected carry input is high.
- R7: Once 80 columns are written, further transfers are ignored. The carry output goes low in the cycle after the completing transfer and stays low until the next latch edge.
- R8: The outputs follow only the holding register. A latch-pulse falling edge copies the line into the holding register, rewinds the fill position to column group 0 and drives the carry output high again. This also applies to a line that is only partly written.
- R9: With `blank_n_i`=1, each column code is 00 for `m_frame_i`=0 and bit 1; 01 for `m_frame_i`=0 and bit 0; 10 for `m_frame_i`=1 and bit 0; 11 for `m_frame_i`=1 and bit 1.
- R10: With `blank_n_i`=0, every column code is 00, whatever the data or `m_frame_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Shift clock; data is taken on its falling edge |
| latch_i | input | 1 | Line-latch pulse; the line is transferred on its falling edge |
| bus_wide_i | input | 1 | 0: 4-bit transfers, 1: 8-bit transfers |
| fill_dir_i | input | 1 | 1: fill upward from column 1, 0: fill downward from column 80 |
| data_i | input | 8 | Display data bus |
| m_frame_i | input | 1 | Frame-alternation phase |
| blank_n_i | input | 1 | Active-low display blanking |
| carry_a_i | input | 1 | Carry pin A input value (active-low enable) |
| carry_a_o | output | 1 | Carry pin A output value (active-low line-full) |
| carry_a_oe | output | 1 | Carry pin A output enable |
| carry_b_i | input | 1 | Carry pin B input value (active-low enable) |
| carry_b_o | output | 1 | Carry pin B output value (active-low line-full) |
| carry_b_oe | output | 1 | Carry pin B output enable |
| col_level_o | output | 160 | Two-bit level code per column, column 1 in bits 1:0 |

## Verification
The bench fills lines in both directions and with both bus widths. The data patterns leave every column distinguishable, so a mirrored or off-by-one column mapping shows up as wrong codes at the edge columns. In 4-bit mode it drives the upper bus bits high, so a design that lets those bits through corrupts neighbouring columns. It sends transfers while the carry input is high and after the line is full; a design that accepts them overwrites latched data or overruns the pointer. It latches a partly written line and then fills again, which exposes a design that does not rewind on the latch edge. It also walks the frame and blanking inputs through every level code, where a swapped table entry shows up as wrong codes on all columns.

// File: rtl/lcd_col_pkg.sv
package lcd_col_pkg;

   typedef enum logic [1:0] {
      LVL_ON_POS  = 2'b00,
      LVL_OFF_POS = 2'b01,
      LVL_OFF_NEG = 2'b10,
      LVL_ON_NEG  = 2'b11
   } lvl_e;

   // Drive level for one column from frame phase and latched bit.
   function automatic logic [1:0] pick_level(input logic phase, input logic bit_v);
      lvl_e lv;
      case ({phase, bit_v})
         2'b01:   lv = LVL_ON_POS;
         2'b00:   lv = LVL_OFF_POS;
         2'b10:   lv = LVL_OFF_NEG;
         default: lv = LVL_ON_NEG;
      endcase
      return lv;
   endfunction

endpackage

// File: rtl/edge_strobe.sv
module edge_strobe #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic fall_o
);
   // Synchroniser stages plus one history flop.
   localparam int CHAIN_W = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("edge_strobe: STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-2:0], sig_i};
   end

   assign fall_o = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];

   // One falling edge yields exactly one strobe cycle.
   assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);

endmodule

// File: rtl/line_fill.sv
module line_fill #(
   parameter int NUM_COLS = 80,
   parameter int NARROW_W = 4,
   parameter int WIDE_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                shift_stb_i,
   input  logic                latch_stb_i,
   input  logic                wide_i,
   input  logic                dir_up_i,
   input  logic                enable_n_i,
   input  logic [WIDE_W-1:0]   data_i,
   output logic [NUM_COLS-1:0] line_o,
   output logic                full_o
);
   localparam int POS_W = $clog2(NUM_COLS + 1);

   if (NUM_COLS % WIDE_W != 0 || NUM_COLS % NARROW_W != 0) begin : g_bad_cols
      $error("line_fill: NUM_COLS must be a multiple of both bus widths");
   end
   if (NARROW_W > WIDE_W) begin : g_bad_width
      $error("line_fill: NARROW_W must not exceed WIDE_W");
   end

   logic [POS_W-1:0]    pos_q, pos_d;
   logic [NUM_COLS-1:0] line_q, line_d;
   logic                accept;
   int                  step;

   assign full_o = (pos_q >= POS_W'(NUM_COLS));
   assign step   = wide_i ? WIDE_W : NARROW_W;
   assign accept = shift_stb_i & ~enable_n_i & ~full_o & ~latch_stb_i;

   always_comb begin
      int col;
      line_d = line_q;
      for (int k = 0; k < WIDE_W; k++) begin
         col = int'(pos_q) + k;
         if (accept && k < step && col < NUM_COLS) begin
            if (dir_up_i) line_d[col] = data_i[k];
            else          line_d[NUM_COLS-1-col] = data_i[k];
         end
      end
   end

   always_comb begin
      if (latch_stb_i) pos_d = '0;
      else if (accept) pos_d = pos_q + POS_W'(step);
      else             pos_d = pos_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         line_q <= '0;
      end else begin
         pos_q  <= pos_d;
         line_q <= line_d;
      end
   end

   assign line_o = line_q;

   assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= POS_W'(NUM_COLS));
   assert_full_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && shift_stb_i && !latch_stb_i) |=> ($stable(line_q) && $stable(pos_q)));
   assert_disabled_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_n_i && shift_stb_i && !latch_stb_i) |=> ($stable(line_q) && $stable(pos_q)));
   assert_latch_rewinds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      latch_stb_i |=> (pos_q == '0));

endmodule

// File: rtl/level_map.sv
module level_map #(
   parameter int NUM_COLS = 80
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  latch_stb_i,
   input  logic [NUM_COLS-1:0]   line_i,
   input  logic                  m_i,
   input  logic                  blank_n_i,
   output logic [2*NUM_COLS-1:0] level_o
);
   import lcd_col_pkg::*;

   logic [NUM_COLS-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           hold_q <= '0;
      else if (latch_stb_i) hold_q <= line_i;
   end

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      assign level_o[2*c +: 2] = blank_n_i ? pick_level(m_i, hold_q[c]) : LVL_ON_POS;
   end

   assert_hold_only_on_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_stb_i |=> $stable(hold_q));
   assert_blank_forces_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_n_i |-> ($countones(level_o) == 0));

endmodule

// File: rtl/lcd_col_loader.sv
module lcd_col_loader #(
   parameter int NUM_COLS    = 80,
   parameter int NARROW_W    = 4,
   parameter int WIDE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sclk_i,
   input  logic                  latch_i,
   input  logic                  bus_wide_i,
   input  logic                  fill_dir_i,
   input  logic [WIDE_W-1:0]     data_i,
   input  logic                  m_frame_i,
   input  logic                  blank_n_i,
   input  logic                  carry_a_i,
   output logic                  carry_a_o,
   output logic                  carry_a_oe,
   input  logic                  carry_b_i,
   output logic                  carry_b_o,
   output logic                  carry_b_oe,
   output logic [2*NUM_COLS-1:0] col_level_o
);
   logic shift_stb, latch_stb, full, enable_n;
   logic [NUM_COLS-1:0] line;

   edge_strobe #(.STAGES(SYNC_STAGES)) u_sclk_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(sclk_i), .fall_o(shift_stb));

   edge_strobe #(.STAGES(SYNC_STAGES)) u_latch_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(latch_i), .fall_o(latch_stb));

   // Carry pin roles follow the fill direction.
   assign enable_n   = fill_dir_i ? carry_b_i : carry_a_i;
   assign carry_a_oe = fill_dir_i;
   assign carry_b_oe = ~fill_dir_i;
   assign carry_a_o  = fill_dir_i ? ~full : 1'b1;
   assign carry_b_o  = fill_dir_i ? 1'b1 : ~full;

   line_fill #(.NUM_COLS(NUM_COLS), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .shift_stb_i(shift_stb), .latch_stb_i(latch_stb),
      .wide_i(bus_wide_i), .dir_up_i(fill_dir_i), .enable_n_i(enable_n),
      .data_i(data_i), .line_o(line), .full_o(full));

   level_map #(.NUM_COLS(NUM_COLS)) u_levels (
      .clk(clk), .rst_n(rst_n), .latch_stb_i(latch_stb), .line_i(line),
      .m_i(m_frame_i), .blank_n_i(blank_n_i), .level_o(col_level_o));

   assert_carry_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      latch_stb |=> (carry_a_o && carry_b_o));

endmodule

// File: tb/lcd_col_loader_tb.sv
module lcd_col_loader_tb_top;
   localparam int NC = 80;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sclk_i = 1'b0, latch_i = 1'b0, bus_wide_i = 1'b0, fill_dir_i = 1'b0;
   logic [7:0] data_i = '0;
   logic m_frame_i = 1'b0, blank_n_i = 1'b1;
   logic carry_a_i = 1'b0, carry_b_i = 1'b0;
   logic carry_a_o, carry_a_oe, carry_b_o, carry_b_oe;
   logic [2*NC-1:0] col_level_o;

   int checks = 0, errors = 0;
   bit exp_line [NC];
   bit exp_hold [NC];
   int exp_pos = 0;

   always #4 clk = ~clk;

   lcd_col_loader dut_i (.*);

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_code(input bit d);
      if (!blank_n_i) return 2'b00;
      case ({m_frame_i, d})
         2'b01: return 2'b00;
         2'b00: return 2'b01;
         2'b10: return 2'b10;
         default: return 2'b11;
      endcase
   endfunction

   task automatic chk_cols(input string req);
      int bad = -1;
      for (int c = 0; c < NC; c++)
         if (bad < 0 && col_level_o[2*c +: 2] !== exp_code(exp_hold[c])) bad = c;
      checks++;
      if (bad >= 0) begin
         errors++;
         $display("FAIL %s column %0d actual=%0b expected=%0b", req, bad + 1,
                  col_level_o[2*bad +: 2], exp_code(exp_hold[bad]));
      end
   endtask

   // One shift-clock pulse; the model applies the transfer from the spec.
   task automatic xfer(input logic [7:0] d);
      bit en;
      int w;
      int col;
      data_i = d;
      sclk_i = 1'b1;
      step(3);
      sclk_i = 1'b0;
      step(5);
      en = fill_dir_i ? !carry_b_i : !carry_a_i;
      w  = bus_wide_i ? 8 : 4;
      if (en && exp_pos < NC) begin
         for (int k = 0; k < w; k++) begin
            col = exp_pos + k;
            if (fill_dir_i) exp_line[col] = d[k];
            else            exp_line[NC-1-col] = d[k];
         end
         exp_pos += w;
      end
   endtask

   task automatic latch_line();
      latch_i = 1'b1;
      step(3);
      latch_i = 1'b0;
      step(5);
      for (int c = 0; c < NC; c++) exp_hold[c] = exp_line[c];
      exp_pos = 0;
   endtask

   task automatic t_reset();
      chk_cols("R1 reset levels");
      chk("R1 carry out idle", {31'd0, carry_b_o}, 32'd1);
   endtask

   task automatic t_fill_up_narrow();
      fill_dir_i = 1'b1; bus_wide_i = 1'b0; carry_b_i = 1'b0;
      for (int t = 0; t < 20; t++) xfer({4'hA, 4'((t * 3 + 5) & 15)});
      chk_cols("R8 no change before latch");
      chk("R7 carry low when full (up)", {31'd0, carry_a_o}, 32'd0);
      latch_line();
      chk_cols("R3 upward narrow mapping");
      chk("R3 column 1 from first bit0", {30'd0, col_level_o[1:0]}, 32'd0);
      chk("R8 carry released by latch", {31'd0, carry_a_o}, 32'd1);
   endtask

   task automatic t_fill_down_wide();
      fill_dir_i = 1'b0; bus_wide_i = 1'b1; carry_a_i = 1'b0;
      for (int t = 0; t < 9; t++) xfer(8'((t * 37 + 11) & 255));
      chk("R7 carry high before full", {31'd0, carry_b_o}, 32'd1);
      xfer(8'hC3);
      chk("R7 carry low when full (down)", {31'd0, carry_b_o}, 32'd0);
      latch_line();
      chk_cols("R4 downward wide mapping");
      chk("R4 column 80 from first bit0", {30'd0, col_level_o[159:158]}, 32'd0);
      chk_cols("R2 wide bus columns");
   endtask

   task automatic t_enable();
      fill_dir_i = 1'b0; bus_wide_i = 1'b1; carry_a_i = 1'b1;
      for (int t = 0; t < 10; t++) xfer(8'hFF);
      chk("R6 no fill while disabled", {31'd0, carry_b_o}, 32'd1);
      fill_dir_i = 1'b1; carry_a_i = 1'b0; carry_b_i = 1'b1;
      for (int t = 0; t < 10; t++) xfer(8'h00);
      chk("R6 pin A ignored as enable when up", {31'd0, carry_a_o}, 32'd1);
      latch_line();
      chk_cols("R6 disabled transfers ignored");
      carry_b_i = 1'b0;
   endtask

   task automatic t_overfill();
      fill_dir_i = 1'b1; bus_wide_i = 1'b1;
      for (int t = 0; t < 10; t++) xfer(8'((t * 91 + 6) & 255));
      for (int t = 0; t < 3; t++) xfer(8'h5A);
      chk("R7 carry stays low", {31'd0, carry_a_o}, 32'd0);
      latch_line();
      chk_cols("R7 transfers after full ignored");
   endtask

   task automatic t_partial_latch();
      fill_dir_i = 1'b0; bus_wide_i = 1'b0; carry_a_i = 1'b0;
      for (int t = 0; t < 3; t++) xfer(8'h0F);
      latch_line();
      chk_cols("R8 partial line latched");
      for (int t = 0; t < 19; t++) xfer(8'((t * 5 + 2) & 15));
      chk("R8 rewound pointer not full at 19", {31'd0, carry_b_o}, 32'd1);
      xfer(8'h09);
      chk("R8 full after 20 from rewind", {31'd0, carry_b_o}, 32'd0);
      latch_line();
      chk_cols("R2 narrow downward line");
   endtask

   task automatic t_levels();
      m_frame_i = 1'b1; step(1);
      chk_cols("R9 frame phase 1");
      m_frame_i = 1'b0; step(1);
      chk_cols("R9 frame phase 0");
   endtask

   task automatic t_blank();
      blank_n_i = 1'b0; m_frame_i = 1'b1; step(1);
      chk("R10 blank with m=1", {31'd0, |col_level_o}, 32'd0);
      m_frame_i = 1'b0; step(1);
      chk("R10 blank with m=0", {31'd0, |col_level_o}, 32'd0);
      blank_n_i = 1'b1; step(1);
      chk_cols("R10 unblank restores");
   endtask

   task automatic t_roles();
      fill_dir_i = 1'b0; step(1);
      chk("R5 down roles", {30'd0, carry_a_oe, carry_b_oe}, 32'b01);
      fill_dir_i = 1'b1; step(1);
      chk("R5 up roles", {30'd0, carry_a_oe, carry_b_oe}, 32'b10);
      chk("R5 inactive pin drives 1", {31'd0, carry_b_o}, 32'd1);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < NC; c++) begin exp_line[c] = 0; exp_hold[c] = 0; end
      step(3);
      rst_n = 1'b1;
      step(3);
      t_reset();
      t_roles();
      t_fill_up_narrow();
      t_levels();
      t_fill_down_wide();
      t_levels();
      t_enable();
      t_overfill();
      t_blank();
      t_partial_latch();
      t_levels();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule